// File: doc/BRIEF.md
# Staged Long-Press Reset Controller

This block turns how long two active-low buttons are held into escalating system events. One button is the power key, the other a dedicated reset key. A third active-low input, the cable-power sense, is only debounced and reported. Each input passes through a two-flop synchronizer and a programmable debounce filter. The filtered levels drive a status vector and a one-cycle change interrupt on every press and every release.

Three hold sources can request a reset: the power key, the reset key, and the two held together. Each has its own enable, a stage-one timer and a stage-two timer, both picked from fixed non-linear tables. When stage one expires, a warning interrupt (a "bark") is raised and stage two starts. When stage two expires, a one-cycle reset request goes out with that source's encoded reset type. A separate stage-three path watches a selectable key combination for a programmable number of seconds and then forces a hard reset. Every request is recorded in a sticky reason register, which only a host write clears.

Time is derived from the system clock. A fine tick occurs every `FINE_DIV` clocks. A millisecond tick occurs every `FINE_PER_MS` fine ticks, and a second is `MS_PER_SEC` millisecond ticks. A host programs the block through a write-only register port.

Top module: `lpress_reset_ctrl`

## Requirements
- R1: After reset, all of these are zero: status, change interrupts, barks, rst_req, reason and pullup_en. Stage three defaults to source "both keys" with a 128 s hold, and the debounce index defaults to 0.
- R2: A level change on any input becomes visible on status only after the new level has held for 1000·2^idx fine ticks, where idx is the 3-bit debounce index. A change that reverts earlier is dropped. Each accepted change, whether press or release, pulses that input's irq_chg bit for one cycle. Bit 0 is the power key, bit 1 the reset key and bit 2 the cable input.
- R3: While an enabled source is held, stage one runs for the ms value selected by its 4-bit index from {0,32,56,80,128,184,272,408,608,904,1352,2048,3072,4480,6720,10256}. On expiry, irq_bark for that source pulses once. Bark bit 0 is the power key, bit 1 the reset key and bit 2 both keys.
- R4: After the bark, stage two runs for the ms value selected by its 3-bit index from {0,10,50,100,250,500,1000,2000}. On expiry, rst_req pulses for one cycle and rst_type carries the source's 3-bit type field. The encodings are soft 0, warm 1, shutdown 4 and hard 7.
- R5: If a source's debounced level drops before a stage expires, its counters clear with no event. The next press starts again at stage one with the full stage-one time.
- R6: A source whose enable bit is 0 produces neither a bark nor a stage-two request, however long it is held.
- R7: The "both keys" source is active only while both debounced key levels are high. It has its own enable, indexes and type.
- R8: Stage three watches one of four sources, selected by a 2-bit code: 0 power key, 1 reset key, 2 either key, 3 both keys. Once the selected condition has held for the programmed whole seconds, it requests type 7. A hold value of 0 requests at once, and values above 128 act as 128. Stage three fires at most once per hold.
- R9: reason is {valid, stage3, source[1:0]}. It is loaded in the cycle rst_req is high. For a stage-two request the source field is 0 power key, 1 reset key or 2 both keys; for a stage-three request it is the selection code. If more than one request fires in the same cycle, stage three wins, then both keys, then the power key, then the reset key. Reason keeps its value until a write to address 6 clears it.
- R10: The pullup_en outputs are bit 0 power key, bit 1 reset key and bit 2 cable. Each follows its programmed pull-up bit.
- R11: The write port is decoded by address. Address 0 is the power key, 1 the reset key and 2 both keys, each with data [3:0] stage-one index, [6:4] stage-two index, [9:7] type, [10] enable and [11] pull-up (bit 11 is ignored for address 2). Address 3 holds the cable pull-up in [11]. Address 4 holds the stage-three hold in [7:0] and the source selection in [9:8]. Address 5 holds the debounce index in [2:0]. A write to address 6 clears reason.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_key_n | input | 1 | Power key, low when pressed |
| rst_key_n | input | 1 | Reset key, low when pressed |
| cbl_n | input | 1 | Cable-power sense, low when present |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 12 | Register write data |
| status | output | 3 | Debounced pressed levels {cable, reset key, power key} |
| irq_chg | output | 3 | One-cycle pulse on each accepted level change |
| irq_bark | output | 3 | One-cycle stage-one expiry pulse {both, reset key, power key} |
| rst_req | output | 1 | One-cycle reset request |
| rst_type | output | 3 | Reset type, valid with rst_req |
| reason | output | 4 | Sticky reason {valid, stage3, source} |
| pullup_en | output | 3 | Pull-up enables {cable, reset key, power key} |

## Verification
The assertions rely on the inputs being clean logic levels that no bench process changes inside the clock edge. They also rely on the write port being the only path into the configuration. Under those conditions, a status change, a bark or a request can only follow a debounced level, and reason can only move on a request or a clear. The stimulus drives the pins and the write port only at falling edges. Each press is held well beyond the programmed debounce and stage times, or released well before them, so every expected event falls in a window computed from the tables. The bench changes configuration only while no source is held.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

   // register addresses
   localparam logic [3:0] A_KEY  = 4'd0;
   localparam logic [3:0] A_RST  = 4'd1;
   localparam logic [3:0] A_BOTH = 4'd2;
   localparam logic [3:0] A_CBL  = 4'd3;
   localparam logic [3:0] A_S3   = 4'd4;
   localparam logic [3:0] A_DBC  = 4'd5;
   localparam logic [3:0] A_CLR  = 4'd6;

   localparam logic [2:0] RT_HARD     = 3'd7;
   localparam int         DBC_BASE    = 1000;
   localparam int         DBC_W       = $clog2(DBC_BASE * 128 + 1);
   localparam int         STG_W       = 14;
   localparam logic [7:0] S3_HOLD_MAX = 8'd128;
   localparam logic [1:0] S3_BOTH     = 2'd3;

   // stage-one time in ms for a 4-bit index
   function automatic logic [STG_W-1:0] s1_ms(input logic [3:0] idx);
      case (idx)
         4'd0:  return 14'd0;
         4'd1:  return 14'd32;
         4'd2:  return 14'd56;
         4'd3:  return 14'd80;
         4'd4:  return 14'd128;
         4'd5:  return 14'd184;
         4'd6:  return 14'd272;
         4'd7:  return 14'd408;
         4'd8:  return 14'd608;
         4'd9:  return 14'd904;
         4'd10: return 14'd1352;
         4'd11: return 14'd2048;
         4'd12: return 14'd3072;
         4'd13: return 14'd4480;
         4'd14: return 14'd6720;
         default: return 14'd10256;
      endcase
   endfunction

   // stage-two time in ms for a 3-bit index
   function automatic logic [STG_W-1:0] s2_ms(input logic [2:0] idx);
      case (idx)
         3'd0: return 14'd0;
         3'd1: return 14'd10;
         3'd2: return 14'd50;
         3'd3: return 14'd100;
         3'd4: return 14'd250;
         3'd5: return 14'd500;
         3'd6: return 14'd1000;
         default: return 14'd2000;
      endcase
   endfunction

endpackage

// File: rtl/lpr_tick_gen.sv
module lpr_tick_gen #(
   parameter int FINE_DIV    = 781,
   parameter int FINE_PER_MS = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic fine_tick,
   output logic ms_tick
);
   localparam int MW = $clog2(FINE_PER_MS + 1);

   if (FINE_DIV < 1)    begin : g_bad_div $error("FINE_DIV must be at least 1"); end
   if (FINE_PER_MS < 2) begin : g_bad_ms  $error("FINE_PER_MS must be at least 2"); end

   // fine tick: every clock, or a divided strobe
   if (FINE_DIV == 1) begin : g_direct
      assign fine_tick = 1'b1;
   end else begin : g_div
      localparam int DW = $clog2(FINE_DIV);
      logic [DW-1:0] dcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dcnt      <= '0;
            fine_tick <= 1'b0;
         end else begin
            fine_tick <= (dcnt == DW'(FINE_DIV - 1));
            if (dcnt == DW'(FINE_DIV - 1)) dcnt <= '0;
            else                           dcnt <= dcnt + 1'b1;
         end
      end
   end

   logic [MW-1:0] mcnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcnt    <= '0;
         ms_tick <= 1'b0;
      end else if (fine_tick) begin
         if (mcnt == MW'(FINE_PER_MS - 1)) begin
            mcnt    <= '0;
            ms_tick <= 1'b1;
         end else begin
            mcnt    <= mcnt + 1'b1;
            ms_tick <= 1'b0;
         end
      end else begin
         ms_tick <= 1'b0;
      end
   end
endmodule

// File: rtl/lpr_debounce.sv
module lpr_debounce
   import lpr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_n,
   input  logic       fine_tick,
   input  logic [2:0] dbc_idx,
   output logic       level,
   output logic       chg
);
   logic [1:0]       sync;
   logic [DBC_W-1:0] cnt;
   logic [DBC_W-1:0] lim;

   assign lim = DBC_W'(DBC_BASE) << dbc_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync  <= '0;
         cnt   <= '0;
         level <= 1'b0;
         chg   <= 1'b0;
      end else begin
         sync <= {sync[0], ~pin_n};
         chg  <= 1'b0;
         if (sync[1] == level) begin
            cnt <= '0;
         end else if (fine_tick) begin
            if (cnt >= lim - 1'b1) begin
               level <= sync[1];
               cnt   <= '0;
               chg   <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/lpr_stage_timer.sv
module lpr_stage_timer
   import lpr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic       enable,
   input  logic       ms_tick,
   input  logic [3:0] s1_idx,
   input  logic [2:0] s2_idx,
   output logic       bark,
   output logic       req
);
   typedef enum logic [1:0] {ST_IDLE, ST_S1, ST_S2, ST_DONE} st_t;

   st_t              st;
   logic [STG_W-1:0] cnt;
   logic [STG_W-1:0] lim1, lim2;

   assign lim1 = s1_ms(s1_idx);
   assign lim2 = s2_ms(s2_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cnt  <= '0;
         bark <= 1'b0;
         req  <= 1'b0;
      end else begin
         bark <= 1'b0;
         req  <= 1'b0;
         if (!active || !enable) begin
            st  <= ST_IDLE;
            cnt <= '0;
         end else begin
            case (st)
               ST_IDLE: begin
                  st  <= ST_S1;
                  cnt <= '0;
               end
               ST_S1: begin
                  if (cnt >= lim1) begin
                     bark <= 1'b1;
                     st   <= ST_S2;
                     cnt  <= '0;
                  end else if (ms_tick) begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_S2: begin
                  if (cnt >= lim2) begin
                     req <= 1'b1;
                     st  <= ST_DONE;
                  end else if (ms_tick) begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: st <= ST_DONE;
            endcase
         end
      end
   end
endmodule

// File: rtl/lpr_hold3.sv
module lpr_hold3
   import lpr_pkg::*;
#(
   parameter int MS_PER_SEC = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic       ms_tick,
   input  logic [7:0] hold_s,
   output logic       fire
);
   localparam int MW = $clog2(MS_PER_SEC + 1);

   if (MS_PER_SEC < 2) begin : g_bad_sec $error("MS_PER_SEC must be at least 2"); end

   logic [MW-1:0] mcnt;
   logic [7:0]    sec;
   logic [7:0]    hold_eff;
   logic          fired;

   assign hold_eff = (hold_s > S3_HOLD_MAX) ? S3_HOLD_MAX : hold_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcnt  <= '0;
         sec   <= '0;
         fired <= 1'b0;
         fire  <= 1'b0;
      end else begin
         fire <= 1'b0;
         if (!active) begin
            mcnt  <= '0;
            sec   <= '0;
            fired <= 1'b0;
         end else if (!fired) begin
            if (sec >= hold_eff) begin
               fire  <= 1'b1;
               fired <= 1'b1;
            end else if (ms_tick) begin
               if (mcnt == MW'(MS_PER_SEC - 1)) begin
                  mcnt <= '0;
                  sec  <= sec + 1'b1;
               end else begin
                  mcnt <= mcnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/lpress_reset_ctrl.sv
module lpress_reset_ctrl
   import lpr_pkg::*;
#(
   parameter int FINE_DIV    = 781,
   parameter int FINE_PER_MS = 64,
   parameter int MS_PER_SEC  = 1000,
   parameter int AW          = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwr_key_n,
   input  logic          rst_key_n,
   input  logic          cbl_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [11:0]   wr_data,
   output logic [2:0]    status,
   output logic [2:0]    irq_chg,
   output logic [2:0]    irq_bark,
   output logic          rst_req,
   output logic [2:0]    rst_type,
   output logic [3:0]    reason,
   output logic [2:0]    pullup_en
);
   localparam int N_IN  = 3;  // power key, reset key, cable
   localparam int N_SRC = 3;  // power key, reset key, both

   if (AW < 3) begin : g_bad_aw $error("AW too small for the register map"); end

   // configuration storage
   logic [3:0] s1_idx [N_SRC];
   logic [2:0] s2_idx [N_SRC];
   logic [2:0] rtype  [N_SRC];
   logic [N_SRC-1:0] en;
   logic [N_IN-1:0]  pu;
   logic [7:0] s3_hold;
   logic [1:0] s3_sel;
   logic [2:0] dbc_idx;
   logic       clr_wr;

   assign clr_wr = wr_en && (wr_addr == AW'(A_CLR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_SRC; i++) begin
            s1_idx[i] <= '0;
            s2_idx[i] <= '0;
            rtype[i]  <= '0;
         end
         en      <= '0;
         pu      <= '0;
         s3_hold <= S3_HOLD_MAX;
         s3_sel  <= S3_BOTH;
         dbc_idx <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < N_SRC; i++) begin
            if (wr_addr == AW'(i)) begin
               s1_idx[i] <= wr_data[3:0];
               s2_idx[i] <= wr_data[6:4];
               rtype[i]  <= wr_data[9:7];
               en[i]     <= wr_data[10];
               if (i < 2) pu[i] <= wr_data[11];
            end
         end
         if (wr_addr == AW'(A_CBL)) pu[2] <= wr_data[11];
         if (wr_addr == AW'(A_S3)) begin
            s3_hold <= wr_data[7:0];
            s3_sel  <= wr_data[9:8];
         end
         if (wr_addr == AW'(A_DBC)) dbc_idx <= wr_data[2:0];
      end
   end

   assign pullup_en = pu;

   // time base
   logic fine_tick, ms_tick;
   lpr_tick_gen #(.FINE_DIV(FINE_DIV), .FINE_PER_MS(FINE_PER_MS)) u_tick (
      .clk(clk), .rst_n(rst_n), .fine_tick(fine_tick), .ms_tick(ms_tick)
   );

   // input filters
   logic [N_IN-1:0] pins_n, lvl, chg;
   assign pins_n = {cbl_n, rst_key_n, pwr_key_n};

   for (genvar g = 0; g < N_IN; g++) begin : g_dbc
      lpr_debounce u_dbc (
         .clk(clk), .rst_n(rst_n), .pin_n(pins_n[g]), .fine_tick(fine_tick),
         .dbc_idx(dbc_idx), .level(lvl[g]), .chg(chg[g])
      );
   end

   assign status  = lvl;
   assign irq_chg = chg;

   // stage one / stage two per source
   logic [N_SRC-1:0] src_act, st_req;
   assign src_act = {lvl[0] & lvl[1], lvl[1], lvl[0]};

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      lpr_stage_timer u_stage (
         .clk(clk), .rst_n(rst_n), .active(src_act[g]), .enable(en[g]),
         .ms_tick(ms_tick), .s1_idx(s1_idx[g]), .s2_idx(s2_idx[g]),
         .bark(irq_bark[g]), .req(st_req[g])
      );
   end

   // stage three
   logic s3_act, s3_fire;
   always_comb begin
      case (s3_sel)
         2'd0:    s3_act = lvl[0];
         2'd1:    s3_act = lvl[1];
         2'd2:    s3_act = lvl[0] | lvl[1];
         default: s3_act = lvl[0] & lvl[1];
      endcase
   end

   lpr_hold3 #(.MS_PER_SEC(MS_PER_SEC)) u_hold3 (
      .clk(clk), .rst_n(rst_n), .active(s3_act), .ms_tick(ms_tick),
      .hold_s(s3_hold), .fire(s3_fire)
   );

   // request arbitration: stage three, both keys, power key, reset key
   logic       req_any;
   logic [2:0] nxt_type;
   logic [3:0] nxt_rsn;
   always_comb begin
      req_any = s3_fire | (|st_req);
      if (s3_fire) begin
         nxt_type = RT_HARD;
         nxt_rsn  = {2'b11, s3_sel};
      end else if (st_req[2]) begin
         nxt_type = rtype[2];
         nxt_rsn  = 4'b1010;
      end else if (st_req[0]) begin
         nxt_type = rtype[0];
         nxt_rsn  = 4'b1000;
      end else begin
         nxt_type = rtype[1];
         nxt_rsn  = 4'b1001;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req  <= 1'b0;
         rst_type <= '0;
         reason   <= '0;
      end else begin
         rst_req <= req_any;
         if (req_any) begin
            rst_type <= nxt_type;
            reason   <= nxt_rsn;
         end else if (clr_wr) begin
            reason <= '0;
         end
      end
   end
endmodule

// File: rtl/lpr_checker.sv
module lpr_checker #(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic [2:0]    status,
   input logic [2:0]    irq_chg,
   input logic [2:0]    irq_bark,
   input logic          rst_req,
   input logic [2:0]    rst_type,
   input logic [3:0]    reason
);
   for (genvar g = 0; g < 3; g++) begin : g_chg
      // R2: a change pulse comes with a flip of that status bit
      p_chg_flips_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
         irq_chg[g] |-> (status[g] != $past(status[g])));
   end

   // R3: power-key bark only while the key was held
   p_bark_key_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_bark[0] |-> $past(status[0]));

   // R3: reset-key bark only while that key was held
   p_bark_rst_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_bark[1] |-> $past(status[1]));

   // R7: combined bark only while both keys were held
   p_bark_both_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_bark[2] |-> ($past(status[0]) && $past(status[1])));

   // R8: a stage-three request is always a hard reset
   p_stage3_hard_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && reason[2]) |-> (rst_type == 3'd7));

   // R9: every request leaves a valid reason
   p_req_sets_reason_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> reason[3]);

   // R9: reason moves only on a request or a clear write
   p_reason_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reason) |-> (rst_req || $past(wr_en && (wr_addr == AW'(6)))));
endmodule

bind lpress_reset_ctrl lpr_checker #(.AW(AW)) u_lpr_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .status(status), .irq_chg(irq_chg), .irq_bark(irq_bark),
   .rst_req(rst_req), .rst_type(rst_type), .reason(reason)
);

// File: tb/test_lpress_reset_ctrl.sv
module test_lpress_reset_ctrl;
   localparam int FPM = 4;   // clocks per ms with FINE_DIV = 1
   localparam int MPS = 8;   // ms per second in this bench
   localparam int TOL = 2 * FPM + 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_key_n = 1'b1, rst_key_n = 1'b1, cbl_n = 1'b1;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [11:0] wr_data = '0;
   logic [2:0]  status, irq_chg, irq_bark, rst_type, pullup_en;
   logic        rst_req;
   logic [3:0]  reason;

   always #10 clk = ~clk;  // 50 MHz

   lpress_reset_ctrl #(.FINE_DIV(1), .FINE_PER_MS(FPM), .MS_PER_SEC(MPS)) i_lpress_reset_ctrl (
      .clk(clk), .rst_n(rst_n), .pwr_key_n(pwr_key_n), .rst_key_n(rst_key_n),
      .cbl_n(cbl_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .status(status), .irq_chg(irq_chg), .irq_bark(irq_bark),
      .rst_req(rst_req), .rst_type(rst_type), .reason(reason), .pullup_en(pullup_en)
   );

   typedef struct {
      int     kind;   // 0 change, 1 bark, 2 request
      int     idx;
      int     rtype;
      int     rsn;
      longint tmin;
      longint tmax;
      string  tag;
   } ev_t;

   ev_t    q[$];
   longint cyc = 0;
   int     n_chk = 0, n_err = 0;
   int     bark_seen = 0, req_seen = 0;
   bit     done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic expect_ev(input int kind, input int idx, input int rt, input int rsn,
                            input longint center, input int tol, input string tag);
      ev_t e;
      e.kind = kind; e.idx = idx; e.rtype = rt; e.rsn = rsn;
      e.tmin = center - tol; e.tmax = center + tol; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic take(input int kind, input int idx, input int rt, input int rsn);
      ev_t e;
      if (q.size() == 0) begin
         chk(1'b0, "R5/R6 unexpected event kind", kind, -1);
         return;
      end
      e = q.pop_front();
      chk(e.kind == kind && e.idx == idx, e.tag, kind * 10 + idx, e.kind * 10 + e.idx);
      chk(cyc >= e.tmin && cyc <= e.tmax, e.tag, cyc, (e.tmin + e.tmax) / 2);
      if (kind == 2) begin
         chk(rt == e.rtype, e.tag, rt, e.rtype);
         chk(rsn == e.rsn, e.tag, rsn, e.rsn);
      end
   endtask

   // monitor: scoreboard side
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int i = 0; i < 3; i++) if (irq_chg[i]) take(0, i, 0, 0);
         for (int i = 0; i < 3; i++) if (irq_bark[i]) begin bark_seen++; take(1, i, 0, 0); end
         if (rst_req) begin req_seen++; take(2, 0, int'(rst_type), int'(reason)); end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [11:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic wait_status(input logic [2:0] mask, input logic [2:0] val);
      do @(negedge clk); while ((status & mask) != val);
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      repeat (20) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (10000 * 15) @(posedge clk);
      chk(1'b0, "watchdog", cyc, 0);
      finish_run();
   end

   initial begin : driver
      longint t, t0;
      int b0, r0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(status == 0 && irq_chg == 0 && irq_bark == 0, "R1 outputs", {status, irq_chg, irq_bark}, 0);
      chk(rst_req == 0 && reason == 0 && pullup_en == 0, "R1 reset/reason/pullup", {rst_req, reason, pullup_en}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R11 / R10: power key s1=32 ms, s2=10 ms, warm, enabled, pull-up; cable pull-up
      wr(4'd0, 12'hC91);
      wr(4'd3, 12'h800);
      @(negedge clk);
      chk(pullup_en == 3'b101, "R10 R11 pull-up map", pullup_en, 3'b101);

      // R2 R3 R4: full power-key sequence
      expect_ev(0, 0, 0, 0, cyc + 1002, 6, "R2 press debounce");
      pwr_key_n = 1'b0;
      wait_status(3'b001, 3'b001);
      t0 = cyc;
      expect_ev(1, 0, 0, 0, t0 + 32 * FPM, TOL, "R3 bark 32ms");
      expect_ev(2, 0, 1, 4'b1000, t0 + 42 * FPM, TOL, "R4 warm request");
      drain();
      chk(reason == 4'b1000, "R9 reason key stage2", reason, 4'b1000);
      expect_ev(0, 0, 0, 0, cyc + 1002, 6, "R2 release debounce");
      pwr_key_n = 1'b1;
      drain();

      // R2: debounce index 1 on the cable input
      wr(4'd5, 12'd1);
      expect_ev(0, 2, 0, 0, cyc + 2002, 6, "R2 debounce idx1 press");
      cbl_n = 1'b0;
      drain();
      chk(status == 3'b100, "R2 cable status", status, 3'b100);
      expect_ev(0, 2, 0, 0, cyc + 2002, 6, "R2 debounce idx1 release");
      cbl_n = 1'b1;
      drain();
      wr(4'd5, 12'd0);

      // R5: early release, then a full restart (s1=408 ms, s2=10 ms, soft)
      wr(4'd0, 12'hC17);
      expect_ev(0, 0, 0, 0, cyc + 1002, 6, "R5 press");
      pwr_key_n = 1'b0;
      wait_status(3'b001, 3'b001);
      b0 = bark_seen; r0 = req_seen;
      expect_ev(0, 0, 0, 0, cyc + 1002, 6, "R5 early release");
      pwr_key_n = 1'b1;
      drain();
      chk(bark_seen == b0 && req_seen == r0, "R5 no event on early release", bark_seen - b0 + req_seen - r0, 0);
      expect_ev(0, 0, 0, 0, cyc + 1002, 6, "R5 re-press");
      pwr_key_n = 1'b0;
      wait_status(3'b001, 3'b001);
      t0 = cyc;
      expect_ev(1, 0, 0, 0, t0 + 408 * FPM, TOL, "R5 restart full stage one");
      expect_ev(2, 0, 0, 4'b1000, t0 + 418 * FPM, TOL, "R4 soft request");
      drain();
      expect_ev(0, 0, 0, 0, cyc + 1002, 6, "R5 release");
      pwr_key_n = 1'b1;
      drain();

      // R6: reset key disabled, long hold
      expect_ev(0, 1, 0, 0, cyc + 1002, 6, "R6 press");
      rst_key_n = 1'b0;
      wait_status(3'b010, 3'b010);
      b0 = bark_seen; r0 = req_seen;
      repeat (2000) @(negedge clk);
      chk(bark_seen == b0, "R6 no bark when disabled", bark_seen - b0, 0);
      chk(req_seen == r0, "R6 no request when disabled", req_seen - r0, 0);
      chk(pullup_en[1] == 1'b0, "R10 reset-key pull-up off", pullup_en[1], 0);
      expect_ev(0, 1, 0, 0, cyc + 1002, 6, "R6 release");
      rst_key_n = 1'b1;
      drain();

      // R7 + R8 default: both keys (s1=56, s2=50, shutdown), then stage three AND 128 s
      wr(4'd0, 12'h800);
      wr(4'd2, 12'h622);
      t = cyc;
      expect_ev(0, 0, 0, 0, t + 1002, 6, "R7 key press");
      expect_ev(0, 1, 0, 0, t + 1002, 6, "R7 reset press");
      pwr_key_n = 1'b0; rst_key_n = 1'b0;
      wait_status(3'b011, 3'b011);
      t0 = cyc;
      expect_ev(1, 2, 0, 0, t0 + 56 * FPM, TOL, "R7 combined bark");
      expect_ev(2, 0, 4, 4'b1010, t0 + 106 * FPM, TOL, "R7 shutdown request");
      expect_ev(2, 0, 7, 4'b1111, t0 + 128 * MPS * FPM, TOL + 6, "R8 default both-keys 128 s");
      drain();
      t = cyc;
      expect_ev(0, 0, 0, 0, t + 1002, 6, "R7 key release");
      expect_ev(0, 1, 0, 0, t + 1002, 6, "R7 reset release");
      pwr_key_n = 1'b1; rst_key_n = 1'b1;
      drain();

      // R8: either key, 2 s hold
      wr(4'd4, 12'h202);
      expect_ev(0, 1, 0, 0, cyc + 1002, 6, "R8 press");
      rst_key_n = 1'b0;
      wait_status(3'b010, 3'b010);
      t0 = cyc;
      expect_ev(2, 0, 7, 4'b1110, t0 + 2 * MPS * FPM, TOL, "R8 either-key hard");
      drain();
      expect_ev(0, 1, 0, 0, cyc + 1002, 6, "R8 release");
      rst_key_n = 1'b1;
      drain();

      // R8: power key, hold 0 fires at once
      wr(4'd4, 12'h000);
      t = cyc;
      expect_ev(0, 0, 0, 0, t + 1002, 6, "R8 press");
      expect_ev(2, 0, 7, 4'b1100, t + 1004, 6, "R8 zero hold");
      pwr_key_n = 1'b0;
      drain();
      expect_ev(0, 0, 0, 0, cyc + 1002, 6, "R8 release");
      pwr_key_n = 1'b1;
      drain();

      // R8: reset key, hold 200 acts as 128
      wr(4'd4, 12'h1C8);
      expect_ev(0, 1, 0, 0, cyc + 1002, 6, "R8 press");
      rst_key_n = 1'b0;
      wait_status(3'b010, 3'b010);
      t0 = cyc;
      expect_ev(2, 0, 7, 4'b1101, t0 + 128 * MPS * FPM, TOL + 6, "R8 hold clamp");
      drain();
      expect_ev(0, 1, 0, 0, cyc + 1002, 6, "R8 release");
      rst_key_n = 1'b1;
      drain();

      // R9: sticky until cleared
      chk(reason == 4'b1101, "R9 reason held after release", reason, 4'b1101);
      wr(4'd5, 12'd0);
      chk(reason == 4'b1101, "R9 other write keeps reason", reason, 4'b1101);
      wr(4'd6, 12'd0);
      chk(reason == 4'b0000, "R9 clear write", reason, 0);

      chk(q.size() == 0, "scoreboard drained", q.size(), 0);
      finish_run();
   end
endmodule